// File: doc/BRIEF.md
# Byte-Addressed I2C Register Target with Row-Wrapped Writes

This block lets an I2C controller read and write a byte-wide register file. It samples SCL and SDA on the fast system clock through a short synchroniser and finds START, repeated START and STOP from the sampled levels. It answers a 7-bit target address whose upper five bits are fixed and whose lower two bits come from pins. Only SDA is driven, and only as an open-drain pull-down enable.

The first byte after a write address loads an internal address counter. Each later byte is handed to the register file as a one-cycle write strobe with address and data. Between bytes the counter steps forward inside its 8-byte row only. Reads start from wherever the counter stands and step through the whole address space. The register file marks which addresses are nonvolatile. If any such byte was written in a transaction that then ends with STOP, a commit timer runs for a set number of clock cycles. While the timer runs, the target refuses its own address, so a controller can poll until it is ready.

Top module: `i2c_paged_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal binary 01010 followed by `addr_sel_i[1]` and `addr_sel_i[0]`. Bit 0 of that byte is 0 for a write and 1 for a read. With `addr_sel_i` = 00 the write address byte is 50h.
- R2: In a write, the first byte after the address sets the address counter. Each later byte gives one `reg_wr_o` pulse carrying the counter value and the byte, and every such byte is acknowledged.
- R3: After each written byte the counter advances only in its low three bits. The upper five bits stay the same, so writing past a row end continues at the first byte of that row.
- R4: A read returns the byte at the current counter, even when no address byte came before it. It sends another byte after each controller ACK, and after a NACK it releases SDA for the rest of the transaction.
- R5: Each byte read advances the counter by one across all eight bits, so a read wraps from FFh to 00h without row wrapping.
- R6: When a STOP ends a transaction in which a byte was written while `reg_nv_i` was high, `busy_o` goes high. A repeated START drops that pending commit, and no later STOP starts one for it.
- R7: `busy_o` stays high for exactly COMMIT_CYCLES clock cycles. While it is high the target NACKs its own address, and once it is low the address is acknowledged again.
- R8: SDA input is sampled on SCL rising edges. `sda_oe_o` changes only while SCL is low, following a falling edge. Bytes go MSB first, and the ninth clock carries the acknowledge.
- R9: After an address that does not match, the target neither acknowledges nor writes anything until the next START.
- R10: Out of reset, `sda_oe_o`, `reg_wr_o` and `busy_o` are low and the address counter is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| addr_sel_i | input | 2 | Pin-selected low address bits |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_addr_o | output | 8 | Register address (write address during a strobe, otherwise the counter) |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o`, combinational |
| reg_nv_i | input | 1 | The addressed byte is nonvolatile |
| busy_o | output | 1 | Commit timer running |

## Verification
The bench writes four bytes starting two below a row end. A design that carried into the upper address bits would overwrite the next row instead of wrapping. A read that starts at FEh checks that read increments do not row-wrap; a design that reused the write rule would return FEh, FFh, F8h. A nonvolatile write that ends in a repeated START must leave the timer idle, and a design that latched the pending flag across the restart would raise busy. The bench also counts how many address attempts are refused during a commit, and a design that did not gate the acknowledge would accept the first attempt.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IGNORE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e        state;
        logic [2:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [ADDR_W-1:0] cnt;
        logic [ADDR_W-1:0] waddr;
        logic [BYTE_W-1:0] wdata;
        logic              wr;
        logic              rw;
        logic              ack_on;
        logic              rack;
        logic              nv_pend;
        logic              commit;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_last;
        logic                   sda_last;
    } samp_t;

    samp_t s_d, s_q;

    logic scl_now;
    logic sda_now;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[SYNC_STAGES-2:0], scl_i};
        s_d.sda_pipe = {s_q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        s_d.scl_last = s_q.scl_pipe[SYNC_STAGES-1];
        s_d.sda_last = s_q.sda_pipe[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_now    = s_q.scl_pipe[SYNC_STAGES-1];
    assign sda_now    = s_q.sda_pipe[SYNC_STAGES-1];
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~s_q.scl_last;
    assign scl_fall_o = ~scl_now & s_q.scl_last;
    assign start_o    = scl_now & s_q.scl_last & s_q.sda_last & ~sda_now;
    assign stop_o     = scl_now & s_q.scl_last & ~s_q.sda_last & sda_now;

endmodule

// File: rtl/nv_commit_timer.sv
module nv_commit_timer #(
    parameter int COMMIT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.remain = CNT_W'(COMMIT_CYCLES);
        end else if (t_q.remain != '0) begin
            t_d.remain = t_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy_o = (t_q.remain != '0);

    // R7: a started commit holds off the bus on the next cycle
    assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_target_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX = 5'b01010,
    parameter int         ROW_BITS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [1:0]        sel_i,
    input  logic              busy_i,
    input  logic              nv_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              sda_oe_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              commit_o
);

    localparam int ROW_HI = ADDR_W - 1;

    tgt_regs_t r_d, r_q;
    logic [BYTE_W-1:0] byte_in;
    logic              last_bit;
    logic              in_ack;

    assign byte_in  = {r_q.shreg[BYTE_W-2:0], sda_i};
    assign last_bit = (r_q.bitcnt == 3'd7);
    assign in_ack   = (r_q.state == ST_ADDR_ACK) || (r_q.state == ST_REG_ACK) ||
                      (r_q.state == ST_WACK);

    always_comb begin
        r_d         = r_q;
        r_d.wr      = 1'b0;
        r_d.commit  = 1'b0;
        r_d.nv_pend = r_q.nv_pend | (r_q.wr & nv_i);
        if (start_i) begin
            r_d.state   = ST_ADDR;
            r_d.bitcnt  = '0;
            r_d.ack_on  = 1'b0;
            r_d.nv_pend = 1'b0;
        end else if (stop_i) begin
            r_d.state   = ST_IDLE;
            r_d.ack_on  = 1'b0;
            r_d.commit  = r_d.nv_pend;
            r_d.nv_pend = 1'b0;
        end else begin
            case (r_q.state)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (rise_i) begin
                        r_d.shreg  = byte_in;
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                        if (last_bit) begin
                            if (r_q.state == ST_ADDR) begin
                                if ((byte_in[BYTE_W-1:1] == {DEV_PREFIX, sel_i}) && !busy_i) begin
                                    r_d.rw    = byte_in[0];
                                    r_d.state = ST_ADDR_ACK;
                                end else begin
                                    r_d.state = ST_IGNORE;
                                end
                            end else if (r_q.state == ST_REG) begin
                                r_d.cnt   = byte_in;
                                r_d.state = ST_REG_ACK;
                            end else begin
                                r_d.wr    = 1'b1;
                                r_d.waddr = r_q.cnt;
                                r_d.wdata = byte_in;
                                r_d.cnt   = {r_q.cnt[ROW_HI:ROW_BITS],
                                             ROW_BITS'(r_q.cnt[ROW_BITS-1:0] + 1'b1)};
                                r_d.state = ST_WACK;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_REG_ACK, ST_WACK: begin
                    if (fall_i) begin
                        if (!r_q.ack_on) begin
                            r_d.ack_on = 1'b1;
                        end else begin
                            r_d.ack_on = 1'b0;
                            r_d.bitcnt = '0;
                            if (r_q.state == ST_ADDR_ACK) begin
                                if (r_q.rw) begin
                                    r_d.state = ST_RDATA;
                                    r_d.shreg = rdata_i;
                                end else begin
                                    r_d.state = ST_REG;
                                end
                            end else begin
                                r_d.state = ST_WDATA;
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (fall_i) begin
                        if (last_bit) begin
                            r_d.state  = ST_RACK;
                            r_d.bitcnt = '0;
                            r_d.cnt    = r_q.cnt + 1'b1;
                        end else begin
                            r_d.shreg  = {r_q.shreg[BYTE_W-2:0], 1'b1};
                            r_d.bitcnt = r_q.bitcnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (rise_i) begin
                        r_d.rack = ~sda_i;
                    end else if (fall_i) begin
                        if (r_q.rack) begin
                            r_d.state = ST_RDATA;
                            r_d.shreg = rdata_i;
                        end else begin
                            r_d.state = ST_IGNORE;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o = (in_ack && r_q.ack_on) ||
                      ((r_q.state == ST_RDATA) && !r_q.shreg[BYTE_W-1]);
    assign wr_o     = r_q.wr;
    assign addr_o   = r_q.wr ? r_q.waddr : r_q.cnt;
    assign wdata_o  = r_q.wdata;
    assign commit_o = r_q.commit;

    // R3: the strobe's row and the counter's row agree after each write
    assert_row_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wr |-> (r_q.cnt[ROW_HI:ROW_BITS] == r_q.waddr[ROW_HI:ROW_BITS]));

    // R7: never acknowledge the address while a commit runs
    assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_ADDR_ACK) && r_q.ack_on) |-> !busy_i);

    // R8: the pull-down only engages following a falling SCL edge
    assert_oe_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(fall_i));

    // R6: a commit request only follows a detected STOP
    assert_commit_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.commit |-> $past(stop_i));

endmodule

// File: rtl/i2c_paged_target.sv
module i2c_paged_target
    import i2c_target_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX    = 5'b01010,
    parameter int         ROW_BITS      = 3,
    parameter int         SYNC_STAGES   = 2,
    parameter int         COMMIT_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        addr_sel_i,
    output logic              reg_wr_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    input  logic [BYTE_W-1:0] reg_rdata_i,
    input  logic              reg_nv_i,
    output logic              busy_o
);

    logic sda_s, rise, fall, start, stop, commit;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_o     (sda_s),
        .scl_rise_o(rise),
        .scl_fall_o(fall),
        .start_o   (start),
        .stop_o    (stop)
    );

    i2c_target_fsm #(.DEV_PREFIX(DEV_PREFIX), .ROW_BITS(ROW_BITS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda_i   (sda_s),
        .rise_i  (rise),
        .fall_i  (fall),
        .start_i (start),
        .stop_i  (stop),
        .sel_i   (addr_sel_i),
        .busy_i  (busy_o),
        .nv_i    (reg_nv_i),
        .rdata_i (reg_rdata_i),
        .sda_oe_o(sda_oe_o),
        .wr_o    (reg_wr_o),
        .addr_o  (reg_addr_o),
        .wdata_o (reg_wdata_o),
        .commit_o(commit)
    );

    nv_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(commit),
        .busy_o (busy_o)
    );

endmodule

// File: tb/i2c_paged_target_test.sv
`timescale 1ns/1ps
module i2c_paged_target_test;

    localparam int COMMIT = 2000;
    localparam int Q      = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] sel = 2'b01;
    logic sda_oe, reg_wr, reg_nv, busy;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic bus_sda;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_cnt;

    typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
    wr_t expq[$];

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    bit oe_prev = 0;
    bit busy_prev = 0;
    int busy_len = 0;
    int last_busy_len = 0;

    always #2.5 clk = ~clk;

    assign bus_sda   = m_sda & ~sda_oe;
    assign reg_rdata = mem[reg_addr];
    assign reg_nv    = (reg_addr < 8'h10);

    i2c_paged_target #(.COMMIT_CYCLES(COMMIT)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe_o(sda_oe),
        .addr_sel_i(sel), .reg_wr_o(reg_wr), .reg_addr_o(reg_addr),
        .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata), .reg_nv_i(reg_nv),
        .busy_o(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // register file storage and per-clock comparison of write strobes
    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            if (expq.size() == 0) begin
                check(0, "R9 unexpected write strobe", {8'h0, reg_addr}, 0);
            end else begin
                wr_t e;
                e = expq.pop_front();
                check(reg_addr == e.a, "R2 write address", reg_addr, e.a);
                check(reg_wdata == e.d, "R2 write data", reg_wdata, e.d);
            end
        end
    end

    // per-clock: SDA enable must hold steady while SCL is high (R8); busy length (R7)
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(m_scl && (sda_oe != oe_prev)), "R8 sda_oe changed while SCL high",
                  sda_oe, oe_prev);
        end
        oe_prev = sda_oe;
        if (busy) busy_len++;
        if (busy_prev && !busy) last_busy_len = busy_len;
        if (!busy) busy_len = 0;
        busy_prev = busy;
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = bus_sda; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic tx_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic rx_byte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {5'b01010, sel, rd};
    endfunction

    task automatic set_ptr(input logic [7:0] a);
        logic ack;
        bus_start();
        tx_byte(dev(1'b0), ack);
        check(ack, "R1 write address ack", ack, 1);
        tx_byte(a, ack);
        check(ack, "R2 register address ack", ack, 1);
        exp_cnt = a;
    endtask

    task automatic wr_data(input logic [7:0] v);
        logic ack;
        expq.push_back({exp_cnt, v});
        exp_mem[exp_cnt] = v;
        tx_byte(v, ack);
        check(ack, "R2 data ack", ack, 1);
        exp_cnt = {exp_cnt[7:3], exp_cnt[2:0] + 3'd1};
    endtask

    task automatic rd_begin(input bit restart);
        logic ack;
        if (restart) bus_rstart(); else bus_start();
        tx_byte(dev(1'b1), ack);
        check(ack, "R4 read address ack", ack, 1);
    endtask

    task automatic rd_data(input logic ack, input string req);
        logic [7:0] v;
        rx_byte(v, ack);
        check(v == exp_mem[exp_cnt], req, v, exp_mem[exp_cnt]);
        exp_cnt = exp_cnt + 8'd1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic ack;
        int tries;
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i) ^ 8'hA5;
            exp_mem[i] = 8'(i) ^ 8'hA5;
        end
        exp_cnt = 8'h00;
        repeat (5) @(negedge clk);
        // R10 reset state
        check(sda_oe == 1'b0, "R10 sda_oe in reset", sda_oe, 0);
        check(reg_wr == 1'b0, "R10 reg_wr in reset", reg_wr, 0);
        check(busy == 1'b0, "R10 busy in reset", busy, 0);
        check(reg_addr == 8'h00, "R10 counter in reset", reg_addr, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4/R10: read without address byte starts at counter 00h
        rd_begin(0);
        rd_data(1'b0, "R4 read from reset counter");
        bus_stop();
        check(sda_oe == 1'b0, "R4 SDA released after NACK", sda_oe, 0);

        // R1/R9: wrong address is NACKed and later bytes are ignored
        bus_start();
        tx_byte(8'h50, ack);
        check(!ack, "R1 mismatched address NACK", ack, 0);
        tx_byte(8'h20, ack);
        check(!ack, "R9 byte after mismatch ignored", ack, 0);
        tx_byte(8'h99, ack);
        check(!ack, "R9 second byte after mismatch ignored", ack, 0);
        bus_stop();

        // R2: volatile multi-byte write, read back with restart
        set_ptr(8'h20);
        wr_data(8'h11); wr_data(8'h22); wr_data(8'h33);
        bus_stop();
        check(busy == 1'b0, "R6 no commit for volatile bytes", busy, 0);
        set_ptr(8'h20);
        rd_begin(1);
        rd_data(1'b1, "R2 readback 20h");
        rd_data(1'b1, "R2 readback 21h");
        rd_data(1'b0, "R2 readback 22h");
        bus_stop();

        // R3: row wrap 2Eh,2Fh,28h,29h
        set_ptr(8'h2E);
        wr_data(8'hC1); wr_data(8'hC2); wr_data(8'hC3); wr_data(8'hC4);
        bus_stop();
        check(expq.size() == 0, "R3 all wrapped writes seen", expq.size(), 0);
        set_ptr(8'h28);
        rd_begin(1);
        for (int i = 0; i < 7; i++) rd_data(1'b1, "R3 row contents after wrap");
        rd_data(1'b0, "R3 row end contents");
        bus_stop();
        check(exp_mem[8'h30] == mem[8'h30], "R3 next row untouched", mem[8'h30], exp_mem[8'h30]);

        // R5: read wraps FFh -> 00h; R4: bare read continues from counter
        set_ptr(8'hFE);
        rd_begin(1);
        rd_data(1'b1, "R5 read FEh");
        rd_data(1'b1, "R5 read FFh");
        rd_data(1'b0, "R5 read wraps to 00h");
        bus_stop();
        rd_begin(0);
        rd_data(1'b0, "R4 bare read continues at 01h");
        bus_stop();

        // R6: nonvolatile write then repeated START gives no commit
        set_ptr(8'h04);
        wr_data(8'h77);
        rd_begin(1);
        rd_data(1'b0, "R6 read after restart");
        bus_stop();
        repeat (20) @(negedge clk);
        check(busy == 1'b0, "R6 restart dropped commit", busy, 0);

        // R6/R7: nonvolatile write ended by STOP starts the commit
        set_ptr(8'h03);
        wr_data(8'h5A);
        bus_stop();
        check(busy == 1'b1, "R6 commit after STOP", busy, 1);
        bus_start();
        tx_byte(dev(1'b0), ack);
        check(!ack, "R7 address NACK while busy", ack, 0);
        bus_stop();
        tries = 1;
        for (int i = 0; i < 20; i++) begin
            bus_start();
            tx_byte(dev(1'b0), ack);
            if (ack) break;
            bus_stop();
            tries++;
        end
        bus_stop();
        check(ack, "R7 address ACK after commit", ack, 1);
        check(tries > 1, "R7 poll needed more than one attempt", tries, 2);
        check(last_busy_len == COMMIT, "R7 busy duration", last_busy_len, COMMIT);

        set_ptr(8'h03);
        rd_begin(1);
        rd_data(1'b0, "R2 nonvolatile byte stored");
        bus_stop();
        check(expq.size() == 0, "R2 no missing writes", expq.size(), 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule